// File: doc/BRIEF.md
# Single-Bit Test and Modify Execution Unit

This unit carries out one single-bit instruction at a time on a 16, 32 or 64 bit operand. The operation is one of four: a plain test, a test followed by complementing the bit, a test followed by clearing it, or a test followed by setting it. The chosen bit is always copied into a carry output. A modifying operation also produces the updated word. The bit position is reduced modulo the operand width. Bits above the width are dropped from every word the unit returns or stores.

Register operands complete one cycle after the request is accepted. The unit returns the new word with a write-enable when the register must be updated. Memory operands address a word at the supplied base plus the bit index shifted arithmetically right by 1, 2 or 3, for widths of 2, 4 or 8 bytes. A negative index therefore reaches below the base. A modifying memory operation issues a locked load, waits for its data, and then issues a locked store of the modified word to the same address. A test on memory performs only an unlocked load. The requester sees `done` with the carry once the last memory response arrives.

Top module: `bit_test_unit`

## Requirements
- R1: For a register operand, `done` is high in the cycle after the request is accepted, and `carry` equals bit (index mod width) of the operand.
- R2: Operation code 01 returns the operand with only the selected bit inverted.
- R3: Operation code 10 returns the operand with only the selected bit cleared, which is the operand ANDed with a rotated all-ones mask whose single zero sits at the selected position.
- R4: Operation code 11 returns the operand with only the selected bit set.
- R5: Operation code 00 leaves `result_we` low for a register operand. `result` then carries the operand truncated to the width.
- R6: The size code 00 selects 16 bits, 01 selects 32 bits, and 10 or 11 selects 64 bits. The bit position is the index modulo that width.
- R7: Bits at or above the operand width are zero in `result` and in `mem_req_wdata`.
- R8: A memory access goes to `req_base` plus the signed bit index shifted arithmetically right by 1, 2 or 3 for the 16, 32 or 64 bit sizes.
- R9: A modifying memory operation first issues a locked read. After the read data returns, it issues a locked write of the modified word to the same address. `done` and the carry follow in the cycle after the write response.
- R10: A memory test issues one unlocked read and no write. `done` follows in the cycle after the read data.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address, direction and lock stay unchanged.
- R12: `req_ready` is high only when the unit is idle. A `req_valid` raised while the unit is busy starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction request |
| req_ready | output | 1 | Unit idle and able to accept |
| req_op | input | 2 | 00 test, 01 complement, 10 clear, 11 set |
| req_size | input | 2 | 00 16-bit, 01 32-bit, 10/11 64-bit |
| req_is_mem | input | 1 | Operand lives in memory |
| req_operand | input | 64 | Register operand value |
| req_index | input | 64 | Signed bit index |
| req_base | input | 64 | Base address for memory operands |
| done | output | 1 | One-cycle completion pulse |
| carry | output | 1 | Value of the tested bit |
| result | output | 64 | Updated (or tested) word, zero above width |
| result_we | output | 1 | Register destination must be written |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 store, 0 load |
| mem_req_lock | output | 1 | Access is part of a locked read-modify-write |
| mem_req_addr | output | 64 | Memory address |
| mem_req_wdata | output | 64 | Store data |
| mem_rsp_valid | input | 1 | Load data or store acknowledge |
| mem_rsp_data | input | 64 | Load data |

## Verification
A fault in the mask lanes or in the width selection shows at the ports in the same cycle as `done`. It appears as a wrong carry, as a neighbouring bit disturbed, or as stray upper bits in `result` or in the store data. A sequencer stuck in or skipping a state is visible within one memory handshake. It shows as a missing or unlocked store, a store issued after a test, a request that drops while stalled, or `req_ready` staying low. Address faults appear in the first load cycle. Negative indices and every size are covered, because the shift amount and the sign extension both change.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    BT_OP_TEST  = 2'b00,
    BT_OP_FLIP  = 2'b01,
    BT_OP_CLEAR = 2'b10,
    BT_OP_SET   = 2'b11
  } bt_op_e;

  typedef enum logic [1:0] {
    BT_SZ_16  = 2'b00,
    BT_SZ_32  = 2'b01,
    BT_SZ_64  = 2'b10,
    BT_SZ_RSV = 2'b11
  } bt_size_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_REQ  = 3'd1,
    ST_RD_WAIT = 3'd2,
    ST_WR_REQ  = 3'd3,
    ST_WR_WAIT = 3'd4
  } bt_state_e;

  localparam int unsigned BT_NUM_LANES = 3;

  function automatic int unsigned bt_lane_of(input bt_size_e sz);
    case (sz)
      BT_SZ_16: return 0;
      BT_SZ_32: return 1;
      default:  return 2;
    endcase
  endfunction

endpackage

// File: rtl/bt_mask_gen.sv
module bt_mask_gen
  import bt_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  bt_op_e             op,
  input  bt_size_e           size,
  input  logic [DATA_W-1:0]  operand,
  input  logic [IDX_W-1:0]   index,
  output logic               bit_val,
  output logic [DATA_W-1:0]  new_word
);

  logic [DATA_W-1:0] lane_word [BT_NUM_LANES];
  logic              lane_bit  [BT_NUM_LANES];

  // One lane per operand width: 16 << g bits. The index is cut to the
  // lane's own bit count, which gives the modulo-width behaviour.
  for (genvar g = 0; g < BT_NUM_LANES; g++) begin : g_lane
    localparam int unsigned LW = 16 << g;
    localparam int unsigned LB = $clog2(LW);

    logic [LW-1:0] opnd;
    logic [LW-1:0] onehot;
    logic [LW-1:0] modified;

    assign opnd   = operand[LW-1:0];
    // shifting a single one is the same as rotating it within the lane
    assign onehot = {{(LW-1){1'b0}}, 1'b1} << index[LB-1:0];

    always_comb begin
      case (op)
        BT_OP_FLIP:  modified = opnd ^ onehot;
        BT_OP_CLEAR: modified = opnd & ~onehot;  // rotated all-ones-but-one
        BT_OP_SET:   modified = opnd | onehot;
        default:     modified = opnd;
      endcase
    end

    always_comb begin
      lane_word[g]         = '0;
      lane_word[g][LW-1:0] = modified;
    end

    assign lane_bit[g] = opnd[index[LB-1:0]];
  end

  always_comb begin
    bit_val  = lane_bit[bt_lane_of(size)];
    new_word = lane_word[bt_lane_of(size)];
  end

endmodule

// File: rtl/bt_addr_calc.sv
module bt_addr_calc
  import bt_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  bt_size_e           size,
  input  logic [DATA_W-1:0]  base,
  input  logic [DATA_W-1:0]  index,
  output logic [DATA_W-1:0]  addr
);

  logic [1:0]        shamt;
  logic [DATA_W-1:0] offset;

  always_comb begin
    case (size)
      BT_SZ_16: shamt = 2'd1;
      BT_SZ_32: shamt = 2'd2;
      default:  shamt = 2'd3;
    endcase
  end

  assign offset = DATA_W'($signed(index) >>> shamt);
  assign addr   = base + offset;

endmodule

// File: rtl/bt_seq.sv
module bt_seq
  import bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       start_is_mem,
  input  logic       cur_is_test,
  input  logic       mem_req_ready,
  input  logic       mem_rsp_valid,
  output logic       idle,
  output logic       rd_req,
  output logic       wr_req,
  output logic       capture,
  output logic       finish
);

  bt_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    capture = 1'b0;
    finish  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (start_is_mem) state_d = ST_RD_REQ;
          else              finish  = 1'b1;
        end
      end
      ST_RD_REQ:  if (mem_req_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT: begin
        if (mem_rsp_valid) begin
          capture = 1'b1;
          if (cur_is_test) begin
            finish  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_WR_REQ;
          end
        end
      end
      ST_WR_REQ:  if (mem_req_ready) state_d = ST_WR_WAIT;
      ST_WR_WAIT: begin
        if (mem_rsp_valid) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign idle   = (state_q == ST_IDLE);
  assign rd_req = (state_q == ST_RD_REQ);
  assign wr_req = (state_q == ST_WR_REQ);

endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
  import bt_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_size,
  input  logic              req_is_mem,
  input  logic [DATA_W-1:0] req_operand,
  input  logic [DATA_W-1:0] req_index,
  input  logic [DATA_W-1:0] req_base,
  output logic              done,
  output logic              carry,
  output logic [DATA_W-1:0] result,
  output logic              result_we,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic              mem_req_lock,
  output logic [DATA_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_data
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // sequencer
  logic idle, rd_req, wr_req, capture, finish, start;
  bt_op_e   op_q;
  bt_size_e size_q;

  assign start = req_valid && idle;

  bt_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .start        (start),
    .start_is_mem (req_is_mem),
    .cur_is_test  (op_q == BT_OP_TEST),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid),
    .idle         (idle),
    .rd_req       (rd_req),
    .wr_req       (wr_req),
    .capture      (capture),
    .finish       (finish)
  );

  // datapath selection: live request while idle, latched fields after
  logic [DATA_W-1:0] index_q, addr_q, result_q, addr_d;
  bt_op_e            mg_op;
  bt_size_e          mg_size;
  logic [DATA_W-1:0] mg_operand;
  logic [IDX_W-1:0]  mg_index;
  logic              mg_bit;
  logic [DATA_W-1:0] mg_word;

  always_comb begin
    if (idle) begin
      mg_op      = bt_op_e'(req_op);
      mg_size    = bt_size_e'(req_size);
      mg_operand = req_operand;
      mg_index   = req_index[IDX_W-1:0];
    end else begin
      mg_op      = op_q;
      mg_size    = size_q;
      mg_operand = mem_rsp_data;
      mg_index   = index_q[IDX_W-1:0];
    end
  end

  bt_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .op      (mg_op),
    .size    (mg_size),
    .operand (mg_operand),
    .index   (mg_index),
    .bit_val (mg_bit),
    .new_word(mg_word)
  );

  bt_addr_calc #(.DATA_W(DATA_W)) u_addr (
    .size  (bt_size_e'(req_size)),
    .base  (req_base),
    .index (req_index),
    .addr  (addr_d)
  );

  // clock enables
  logic accept_en, data_en;
  assign accept_en = start;
  assign data_en   = (start && !req_is_mem) || capture;

  logic carry_q, done_q, we_q;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      op_q    <= BT_OP_TEST;
      size_q  <= BT_SZ_16;
      index_q <= '0;
      addr_q  <= '0;
    end else if (accept_en) begin
      op_q    <= bt_op_e'(req_op);
      size_q  <= bt_size_e'(req_size);
      index_q <= req_index;
      addr_q  <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      carry_q  <= 1'b0;
      result_q <= '0;
    end else if (data_en) begin
      carry_q  <= mg_bit;
      result_q <= mg_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      done_q <= 1'b0;
      we_q   <= 1'b0;
    end else begin
      done_q <= finish;
      we_q   <= start && !req_is_mem && (bt_op_e'(req_op) != BT_OP_TEST);
    end
  end

  assign req_ready     = idle;
  assign done          = done_q;
  assign carry         = carry_q;
  assign result        = result_q;
  assign result_we     = we_q;
  assign mem_req_valid = rd_req || wr_req;
  assign mem_req_write = wr_req;
  assign mem_req_lock  = (op_q != BT_OP_TEST);
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = result_q;

  // width mask of the operation that just finished, for the checks below
  logic [DATA_W-1:0] wmask_q;
  always_comb begin
    case (size_q)
      BT_SZ_16: wmask_q = DATA_W'({16{1'b1}});
      BT_SZ_32: wmask_q = DATA_W'({32{1'b1}});
      default:  wmask_q = '1;
    endcase
  end

  AST_STORE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n_int)
    mem_req_valid && mem_req_write |-> mem_req_lock) else $error("store unlocked"); // R9

  AST_TEST_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n_int)
    mem_req_valid && mem_req_write |-> op_q != BT_OP_TEST) else $error("store on test"); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n_int)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_lock))
    else $error("request dropped"); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    done |-> req_ready) else $error("done while busy"); // R12

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    done |-> (result & ~wmask_q) == '0) else $error("upper bits set"); // R7

  AST_WE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n_int)
    result_we |-> done && op_q != BT_OP_TEST) else $error("stray write enable"); // R5

endmodule

// File: tb/bit_test_unit_tb.sv
`timescale 1ns/1ps
module bit_test_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_is_mem;
  logic [1:0]  req_op, req_size;
  logic [63:0] req_operand, req_index, req_base;
  logic        req_ready, done, carry, result_we;
  logic [63:0] result;
  logic        mem_req_valid, mem_req_ready, mem_req_write, mem_req_lock;
  logic [63:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bit_test_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_size(req_size), .req_is_mem(req_is_mem),
    .req_operand(req_operand), .req_index(req_index), .req_base(req_base),
    .done(done), .carry(carry), .result(result), .result_we(result_we),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_lock(mem_req_lock),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int width_of(input logic [1:0] sz);
    return (sz == 2'b00) ? 16 : (sz == 2'b01) ? 32 : 64;
  endfunction

  // reference model built from the requirement text
  function automatic void ref_op(input logic [1:0] op, input logic [1:0] sz,
                                 input logic [63:0] opnd, input logic [63:0] idx,
                                 output logic c, output logic [63:0] w);
    int wd = width_of(sz);
    int b  = int'(idx[5:0]) % wd;
    logic [63:0] m = (wd == 64) ? '1 : ((64'd1 << wd) - 64'd1);
    c = opnd[b];
    case (op)
      2'b01:   w = opnd ^ (64'd1 << b);
      2'b10:   w = opnd & ~(64'd1 << b);
      2'b11:   w = opnd | (64'd1 << b);
      default: w = opnd;
    endcase
    w = w & m;
  endfunction

  function automatic logic [63:0] ref_addr(input logic [1:0] sz, input logic [63:0] base,
                                           input logic [63:0] idx);
    int sh = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 3;
    return base + 64'($signed(idx) >>> sh);
  endfunction

  task automatic drive_req(input logic [1:0] op, input logic [1:0] sz, input logic mem,
                           input logic [63:0] opnd, input logic [63:0] idx, input logic [63:0] base);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_size = sz; req_is_mem = mem;
    req_operand = opnd; req_index = idx; req_base = base;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic test_reset();
    chk("R12 ready after reset", {63'd0, req_ready}, 64'd1);
    chk("R1 done low after reset", {63'd0, done}, 64'd0);
    chk("R11 no mem request after reset", {63'd0, mem_req_valid}, 64'd0);
  endtask

  task automatic test_reg(input string tag, input logic [1:0] op, input logic [1:0] sz,
                          input logic [63:0] opnd, input logic [63:0] idx);
    logic c; logic [63:0] w;
    ref_op(op, sz, opnd, idx, c, w);
    drive_req(op, sz, 1'b0, opnd, idx, 64'd0);
    chk({tag, " R1 done"}, {63'd0, done}, 64'd1);
    chk({tag, " R1 carry"}, {63'd0, carry}, {63'd0, c});
    chk({tag, " result"}, result, w);
    chk({tag, " R5 write enable"}, {63'd0, result_we}, {63'd0, op != 2'b00});
    chk({tag, " R11 no mem traffic"}, {63'd0, mem_req_valid}, 64'd0);
    @(negedge clk);
    chk({tag, " R1 done pulse"}, {63'd0, done}, 64'd0);
  endtask

  task automatic test_mem(input string tag, input logic [1:0] op, input logic [1:0] sz,
                          input logic [63:0] data, input logic [63:0] idx, input logic [63:0] base);
    logic c; logic [63:0] w, a;
    ref_op(op, sz, data, idx, c, w);
    a = ref_addr(sz, base, idx);
    drive_req(op, sz, 1'b1, 64'hDEAD, idx, base);
    chk({tag, " R12 busy"}, {63'd0, req_ready}, 64'd0);
    chk({tag, " R9 read valid"}, {63'd0, mem_req_valid}, 64'd1);
    chk({tag, " R10 read dir"}, {63'd0, mem_req_write}, 64'd0);
    chk({tag, " R9 read lock"}, {63'd0, mem_req_lock}, {63'd0, op != 2'b00});
    chk({tag, " R8 address"}, mem_req_addr, a);
    @(negedge clk);
    chk({tag, " R11 held valid"}, {63'd0, mem_req_valid}, 64'd1);
    chk({tag, " R11 held addr"}, mem_req_addr, a);
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk({tag, " R9 read retired"}, {63'd0, mem_req_valid}, 64'd0);
    mem_rsp_valid = 1'b1; mem_rsp_data = data;
    @(negedge clk);
    mem_rsp_valid = 1'b0; mem_rsp_data = 64'h0;
    if (op == 2'b00) begin
      chk({tag, " R10 done"}, {63'd0, done}, 64'd1);
      chk({tag, " R10 carry"}, {63'd0, carry}, {63'd0, c});
      chk({tag, " R10 no store"}, {63'd0, mem_req_valid}, 64'd0);
    end else begin
      chk({tag, " R9 not done yet"}, {63'd0, done}, 64'd0);
      chk({tag, " R9 store valid"}, {63'd0, mem_req_valid}, 64'd1);
      chk({tag, " R9 store dir"}, {63'd0, mem_req_write}, 64'd1);
      chk({tag, " R9 store lock"}, {63'd0, mem_req_lock}, 64'd1);
      chk({tag, " R9 store addr"}, mem_req_addr, a);
      chk({tag, " R7 store data"}, mem_req_wdata, w);
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b1;
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      chk({tag, " R9 done"}, {63'd0, done}, 64'd1);
      chk({tag, " R9 carry"}, {63'd0, carry}, {63'd0, c});
    end
    chk({tag, " R5 no reg write"}, {63'd0, result_we}, 64'd0);
    chk({tag, " R12 idle again"}, {63'd0, req_ready}, 64'd1);
  endtask

  task automatic test_busy_ignore();
    drive_req(2'b00, 2'b10, 1'b1, 64'd0, 64'd9, 64'h100);
    req_valid = 1'b1; req_is_mem = 1'b0; req_op = 2'b11; req_operand = 64'd0;
    chk("R12 ready low while busy", {63'd0, req_ready}, 64'd0);
    mem_req_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b1; mem_rsp_data = 64'h200;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R12 original op done", {63'd0, done}, 64'd1);
    chk("R12 original carry", {63'd0, carry}, 64'd1);
    @(negedge clk);
    chk("R12 ignored request no done", {63'd0, done}, 64'd0);
    chk("R12 ignored request no write", {63'd0, result_we}, 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 2'b00; req_size = 2'b00; req_is_mem = 1'b0;
    req_operand = '0; req_index = '0; req_base = '0;
    mem_req_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();

    test_reg("R4 set 64b top bit", 2'b11, 2'b10, 64'h0123_4567_89AB_CDEF, 64'd63);
    test_reg("R3 clear 32b", 2'b10, 2'b01, 64'hFFFF_FFFF_FFFF_FFFF, 64'd5);
    test_reg("R2 flip 16b R6 modulo", 2'b01, 2'b00, 64'hAAAA_5555_0000_F0F0, 64'd20);
    test_reg("R5 test 64b", 2'b00, 2'b10, 64'h8000_0000_0000_0001, 64'd0);
    test_reg("R6 reserved size as 64b", 2'b11, 2'b11, 64'd0, 64'd40);
    test_reg("R6 32b index 100", 2'b01, 2'b01, 64'hFFFF_0000_0000_0010, 64'd100);
    test_reg("R7 test 16b truncates", 2'b00, 2'b00, 64'hFFFF_FFFF_FFFF_7FFF, 64'd15);

    test_mem("R8 set 32b negative index", 2'b11, 2'b01, 64'h1234_5678_0000_0000, -64'sd5, 64'h1000);
    test_mem("R9 flip 64b", 2'b01, 2'b10, 64'hFFFF_FFFF_0000_0000, 64'd200, 64'h8000);
    test_mem("R3 clear 16b", 2'b10, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, 64'd17, 64'h40);
    test_mem("R10 test 16b", 2'b00, 2'b00, 64'h0000_0000_0000_0002, 64'd33, 64'h2000);

    test_busy_ignore();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule